// File: doc/BRIEF.md
# Function Address Pair Table

This block is a small fully associative table that remembers, for each function the surrounding return-prediction logic has identified, the address where the function starts (entry address) and the address of its return instruction (exit address). Each record also carries an outstanding flag. When the flag is set, at least one return-stack entry currently refers to that entry address, so a new call to the same function is recursive.

The table answers two lookups in the same cycle they are presented. A call lookup, keyed by a call target, reports whether any record has that entry address and whether that function is outstanding. A return lookup, keyed by an exit address, reports whether a record matches and which entry address it is paired with. Three kinds of update are registered on the clock edge: insertion of a new entry/exit pair, setting the outstanding flag for an entry address after a push, and clearing that flag after the stack pops the last entry for that address. Set and clear act on every record that holds the given entry address.

When the table is full, a new pair replaces a record in round-robin order. An insert of a pair that is already present leaves the table as it is, so the table never holds duplicates.

Top module: `fn_pair_table`

## Requirements
- R1: A synchronous active-low reset invalidates every record, so every call and return lookup misses until new pairs are inserted.
- R2: The call lookup reports a hit when any valid record holds the presented entry address. In the same cycle it reports the OR of the outstanding flags of all such records. The result reflects the table contents before that cycle's update.
- R3: The return lookup reports a hit when any valid record holds the presented exit address, and it returns that record's entry address in the same cycle. When several records match, the lowest-numbered one wins. On a miss the returned address is zero.
- R4: An insert of a pair not yet present writes the lowest-numbered free record. The new record is visible to lookups from the next cycle. Its outstanding flag starts as the OR of the flags of the other valid records with the same entry address (zero if there are none), and that cycle's set and clear requests then apply to it.
- R5: An insert whose entry and exit pair already exists in a valid record allocates nothing and does not move the replacement order.
- R6: When every record is valid, a new pair overwrites the record selected by a round-robin pointer. The pointer starts at record 0 after reset, advances by one (wrapping to 0) on each such replacement, and does not move otherwise.
- R7: A set request sets the outstanding flag of every valid record holding its entry address. The effect is visible from the next cycle.
- R8: A clear request clears the outstanding flag of every valid record holding its entry address. The effect is visible from the next cycle.
- R9: When a set and a clear name the same entry address in one cycle, the matching flags end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_key | input | ADDR_W | Entry address for the call lookup |
| call_hit | output | 1 | Some record holds call_key as entry address |
| call_outstanding | output | 1 | OR of outstanding flags of records matching call_key |
| ret_key | input | ADDR_W | Exit address for the return lookup |
| ret_hit | output | 1 | Some record holds ret_key as exit address |
| ret_entry | output | ADDR_W | Entry address paired with ret_key (zero on miss) |
| ins_valid | input | 1 | Insert request |
| ins_entry | input | ADDR_W | Entry address of the pair to insert |
| ins_exit | input | ADDR_W | Exit address of the pair to insert |
| set_valid | input | 1 | Set-outstanding request |
| set_entry | input | ADDR_W | Entry address whose flags are set |
| clr_valid | input | 1 | Clear-outstanding request |
| clr_entry | input | ADDR_W | Entry address whose flags are cleared |

## Verification
The assertions assume that the request inputs are driven to known values in every cycle after reset and that the caller issues at most one insert, one set and one clear per cycle. They also assume set and clear keys are meaningful only when their valid bits are high. The stimulus drives every input at the falling edge from a table of vectors and holds all valid bits low between operations. It drives keys of unused requests to zero and checks the lookup outputs one nanosecond before the rising edge, so each check sees the contents left by the previous update. The vector sequence fills the table, inserts a duplicate, wraps the replacement pointer and leaves a record whose flag comes only from inheritance, so each flag rule is seen at the ports.

// File: rtl/fn_pair_pkg.sv
// Package: shared helpers for the function address pair table.
// Assumes table sizes of at least one record.
package fn_pair_pkg;
    // Index width for a table of n records, never below one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/fn_pair_match.sv
// Module: compares one key against one address field of every record.
// Produces a per-record hit vector, gated by the record valid bits.
// Assumes the field array is indexed by record number.
module fn_pair_match #(
    parameter int unsigned NREC   = 8,
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]           key,
    input  logic [NREC-1:0][ADDR_W-1:0] field,
    input  logic [NREC-1:0]             valid,
    output logic [NREC-1:0]             hit
);
    for (genvar g = 0; g < NREC; g++) begin : g_cmp
        // Per-record equality, masked by validity.
        assign hit[g] = valid[g] && (field[g] == key);
    end
endmodule

// File: rtl/fn_pair_prio.sv
// Module: lowest-index priority selector.
// Reports whether any request bit is set and the index of the lowest one.
// Assumes nothing about the request pattern; index is zero when none is set.
module fn_pair_prio #(
    parameter int unsigned NREC = 8,
    localparam int unsigned IW  = fn_pair_pkg::idx_width(NREC)
) (
    input  logic [NREC-1:0] req,
    output logic            any,
    output logic [IW-1:0]   idx
);
    // Scan from the top down so the lowest set bit is assigned last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NREC - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fn_pair_victim.sv
// Module: picks the record written by a new insert.
// A free record is preferred (lowest index); when none is free a round-robin
// pointer selects the record to overwrite and then advances.
// Assumes alloc is high only for inserts of pairs not already stored.
module fn_pair_victim #(
    parameter int unsigned NREC = 8,
    localparam int unsigned IW  = fn_pair_pkg::idx_width(NREC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREC-1:0] free_vec,
    input  logic            alloc,
    output logic [NREC-1:0] wr_vec
);
    logic          any_free;
    logic [IW-1:0] free_idx;
    logic [IW-1:0] rr_q;
    logic          replace;

    fn_pair_prio #(.NREC(NREC)) u_free_prio (
        .req (free_vec),
        .any (any_free),
        .idx (free_idx)
    );

    assign replace = alloc && !any_free;

    // Round-robin pointer: moves only when a full table replaces a record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (replace) begin
            rr_q <= (rr_q == IW'(NREC - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // One-hot write select from either the free slot or the pointer.
    always_comb begin
        wr_vec = '0;
        if (alloc) begin
            wr_vec[any_free ? free_idx : rr_q] = 1'b1;
        end
    end

    assert_rr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rr_q <= IW'(NREC - 1));

    assert_rr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        replace |=> (rr_q == (($past(rr_q) == IW'(NREC - 1)) ? '0 : $past(rr_q) + 1'b1)));

    assert_rr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !replace |=> $stable(rr_q));

    assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec) && (alloc == (wr_vec != '0)));
endmodule

// File: rtl/fn_pair_table.sv
// Module: function address pair table (top).
// Holds entry/exit address pairs with an outstanding flag each, answers
// combinational call and return lookups, and applies insert, set and clear
// requests on the clock edge. Assumes at most one request of each kind per
// cycle; set beats clear when both name the same entry address.
module fn_pair_table #(
    parameter int unsigned NREC   = 8,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] call_key,
    output logic              call_hit,
    output logic              call_outstanding,
    input  logic [ADDR_W-1:0] ret_key,
    output logic              ret_hit,
    output logic [ADDR_W-1:0] ret_entry,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_entry,
    input  logic [ADDR_W-1:0] ins_exit,
    input  logic              set_valid,
    input  logic [ADDR_W-1:0] set_entry,
    input  logic              clr_valid,
    input  logic [ADDR_W-1:0] clr_entry
);
    localparam int unsigned IW = fn_pair_pkg::idx_width(NREC);

    logic [NREC-1:0][ADDR_W-1:0] ent_q;
    logic [NREC-1:0][ADDR_W-1:0] ext_q;
    logic [NREC-1:0]             vld_q;
    logic [NREC-1:0]             out_q;

    logic [NREC-1:0] call_vec, ret_vec, ins_ent_vec, ins_ext_vec;
    logic [NREC-1:0] set_match, clr_match, set_vec, clr_vec;
    logic [NREC-1:0] dup_vec, wr_vec;
    logic [IW-1:0]   ret_idx;
    logic            ret_any;
    logic            alloc;
    logic            inherit;
    logic            new_set, new_clr;

    fn_pair_match #(.NREC(NREC), .ADDR_W(ADDR_W)) u_call_match (
        .key(call_key), .field(ent_q), .valid(vld_q), .hit(call_vec));
    fn_pair_match #(.NREC(NREC), .ADDR_W(ADDR_W)) u_ret_match (
        .key(ret_key), .field(ext_q), .valid(vld_q), .hit(ret_vec));
    fn_pair_match #(.NREC(NREC), .ADDR_W(ADDR_W)) u_ins_ent_match (
        .key(ins_entry), .field(ent_q), .valid(vld_q), .hit(ins_ent_vec));
    fn_pair_match #(.NREC(NREC), .ADDR_W(ADDR_W)) u_ins_ext_match (
        .key(ins_exit), .field(ext_q), .valid(vld_q), .hit(ins_ext_vec));
    fn_pair_match #(.NREC(NREC), .ADDR_W(ADDR_W)) u_set_match (
        .key(set_entry), .field(ent_q), .valid(vld_q), .hit(set_match));
    fn_pair_match #(.NREC(NREC), .ADDR_W(ADDR_W)) u_clr_match (
        .key(clr_entry), .field(ent_q), .valid(vld_q), .hit(clr_match));

    fn_pair_prio #(.NREC(NREC)) u_ret_prio (
        .req(ret_vec), .any(ret_any), .idx(ret_idx));

    // Lookup outputs, taken from the registered contents.
    assign call_hit         = |call_vec;
    assign call_outstanding = |(call_vec & out_q);
    assign ret_hit          = ret_any;
    assign ret_entry        = ret_any ? ent_q[ret_idx] : '0;

    // Insert classification: duplicate pairs allocate nothing.
    assign dup_vec = ins_ent_vec & ins_ext_vec;
    assign alloc   = ins_valid && (dup_vec == '0);

    fn_pair_victim #(.NREC(NREC)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .free_vec (~vld_q),
        .alloc    (alloc),
        .wr_vec   (wr_vec)
    );

    // Flag requests broadcast to every record sharing the entry address.
    assign set_vec = set_match & {NREC{set_valid}};
    assign clr_vec = clr_match & {NREC{clr_valid}};

    // Starting flag of a freshly written record and same-cycle requests on it.
    assign inherit = |(ins_ent_vec & out_q & ~wr_vec);
    assign new_set = set_valid && (set_entry == ins_entry);
    assign new_clr = clr_valid && (clr_entry == ins_entry);

    // Record storage: write the selected slot, update flags elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            out_q <= '0;
            ent_q <= '0;
            ext_q <= '0;
        end else begin
            for (int i = 0; i < NREC; i++) begin
                if (wr_vec[i]) begin
                    vld_q[i] <= 1'b1;
                    ent_q[i] <= ins_entry;
                    ext_q[i] <= ins_exit;
                    out_q[i] <= new_set || (inherit && !new_clr);
                end else begin
                    out_q[i] <= set_vec[i] || (out_q[i] && !clr_vec[i]);
                end
            end
        end
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0));

    assert_ret_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hit |-> call_hit || (call_key != ret_entry));

    for (genvar g = 0; g < NREC; g++) begin : g_chk
        assert_set_applies_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[g] && !wr_vec[g]) |=> out_q[g]);

        assert_clear_applies_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[g] && !set_vec[g] && !wr_vec[g]) |=> !out_q[g]);

        assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[g] && clr_vec[g]) |=> out_q[g]);

        assert_dup_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_valid && dup_vec[g]) |=> ($stable(ent_q[g]) && $stable(ext_q[g]) && vld_q[g]));

        for (genvar h = g + 1; h < NREC; h++) begin : g_pair
            assert_no_duplicate_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !(vld_q[g] && vld_q[h] && (ent_q[g] == ent_q[h]) && (ext_q[g] == ext_q[h])));
        end
    end
endmodule

// File: tb/fn_pair_table_bench.sv
// Bench: walks a table of request vectors with expected lookup results,
// then runs directed reset checks.
module fn_pair_table_bench;
    localparam int unsigned NREC   = 4;
    localparam int unsigned ADDR_W = 16;

    typedef struct packed {
        logic        iv;
        logic [15:0] ie;
        logic [15:0] ix;
        logic        sv;
        logic [15:0] se;
        logic        cv;
        logic [15:0] ce;
        logic [15:0] ca;
        logic [15:0] ra;
        logic        ech;
        logic        eco;
        logic        erh;
        logic [15:0] ere;
    } vec_t;

    // Expected values describe the table before the vector's own update.
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1,16'h0700,16'h0800, 1'b0,16'h0,     1'b0,16'h0,     16'h0700,16'h0800, 1'b0,1'b0,1'b0,16'h0000}, // R4 insert first pair
        '{1'b0,16'h0,   16'h0,    1'b1,16'h0700,  1'b0,16'h0,     16'h0700,16'h0800, 1'b1,1'b0,1'b1,16'h0700}, // R7 set
        '{1'b0,16'h0,   16'h0,    1'b0,16'h0,     1'b0,16'h0,     16'h0700,16'h0800, 1'b1,1'b1,1'b1,16'h0700}, // R7 visible
        '{1'b0,16'h0,   16'h0,    1'b1,16'h0700,  1'b1,16'h0700,  16'h0700,16'h0800, 1'b1,1'b1,1'b1,16'h0700}, // R9 set+clear
        '{1'b0,16'h0,   16'h0,    1'b0,16'h0,     1'b1,16'h0700,  16'h0700,16'h0900, 1'b1,1'b1,1'b0,16'h0000}, // R9 held, R8 clear
        '{1'b1,16'h0700,16'h0900, 1'b0,16'h0,     1'b0,16'h0,     16'h0700,16'h0900, 1'b1,1'b0,1'b0,16'h0000}, // R8 cleared
        '{1'b0,16'h0,   16'h0,    1'b1,16'h0700,  1'b0,16'h0,     16'h0700,16'h0900, 1'b1,1'b0,1'b1,16'h0700}, // R7 set both
        '{1'b1,16'h0700,16'h0800, 1'b0,16'h0,     1'b0,16'h0,     16'h0700,16'h0800, 1'b1,1'b1,1'b1,16'h0700}, // R5 duplicate
        '{1'b1,16'h0A00,16'h0B00, 1'b0,16'h0,     1'b0,16'h0,     16'h0700,16'h0B00, 1'b1,1'b1,1'b0,16'h0000}, // R4 slot 2
        '{1'b0,16'h0,   16'h0,    1'b1,16'h0A00,  1'b0,16'h0,     16'h0A00,16'h0B00, 1'b1,1'b0,1'b1,16'h0A00},
        '{1'b1,16'h0A00,16'h0C00, 1'b0,16'h0,     1'b0,16'h0,     16'h0A00,16'h0C00, 1'b1,1'b1,1'b0,16'h0000}, // R4 inherit
        '{1'b0,16'h0,   16'h0,    1'b0,16'h0,     1'b0,16'h0,     16'h0A00,16'h0C00, 1'b1,1'b1,1'b1,16'h0A00},
        '{1'b1,16'h0D00,16'h0E00, 1'b0,16'h0,     1'b0,16'h0,     16'h0D00,16'h0800, 1'b0,1'b0,1'b1,16'h0700}, // R6 replace slot 0
        '{1'b1,16'h0F00,16'h0F10, 1'b0,16'h0,     1'b0,16'h0,     16'h0D00,16'h0800, 1'b1,1'b0,1'b0,16'h0000}, // R6 slot 1
        '{1'b1,16'h1100,16'h1200, 1'b0,16'h0,     1'b0,16'h0,     16'h0700,16'h0900, 1'b0,1'b0,1'b0,16'h0000}, // R6 slot 2
        '{1'b0,16'h0,   16'h0,    1'b0,16'h0,     1'b0,16'h0,     16'h0A00,16'h0B00, 1'b1,1'b1,1'b0,16'h0000}, // R4 inherited flag alone
        '{1'b0,16'h0,   16'h0,    1'b0,16'h0,     1'b1,16'h0A00,  16'h0A00,16'h1200, 1'b1,1'b1,1'b1,16'h1100}, // R8
        '{1'b0,16'h0,   16'h0,    1'b0,16'h0,     1'b0,16'h0,     16'h0A00,16'h0F10, 1'b1,1'b0,1'b1,16'h0F00},
        '{1'b1,16'h1300,16'h1400, 1'b0,16'h0,     1'b0,16'h0,     16'h1100,16'h0C00, 1'b1,1'b0,1'b1,16'h0A00}, // R6 slot 3
        '{1'b0,16'h0,   16'h0,    1'b0,16'h0,     1'b0,16'h0,     16'h0A00,16'h1400, 1'b0,1'b0,1'b1,16'h1300},
        '{1'b1,16'h1500,16'h1600, 1'b0,16'h0,     1'b0,16'h0,     16'h0D00,16'h0E00, 1'b1,1'b0,1'b1,16'h0D00}, // R6 wrap to 0
        '{1'b0,16'h0,   16'h0,    1'b0,16'h0,     1'b0,16'h0,     16'h0D00,16'h1600, 1'b0,1'b0,1'b1,16'h1500}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] call_key = '0, ret_key = '0;
    logic              call_hit, call_outstanding, ret_hit;
    logic [ADDR_W-1:0] ret_entry;
    logic              ins_valid = 1'b0, set_valid = 1'b0, clr_valid = 1'b0;
    logic [ADDR_W-1:0] ins_entry = '0, ins_exit = '0, set_entry = '0, clr_entry = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fn_pair_table #(.NREC(NREC), .ADDR_W(ADDR_W)) u_fn_pair_table (
        .clk(clk), .rst_n(rst_n),
        .call_key(call_key), .call_hit(call_hit), .call_outstanding(call_outstanding),
        .ret_key(ret_key), .ret_hit(ret_hit), .ret_entry(ret_entry),
        .ins_valid(ins_valid), .ins_entry(ins_entry), .ins_exit(ins_exit),
        .set_valid(set_valid), .set_entry(set_entry),
        .clr_valid(clr_valid), .clr_entry(clr_entry)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 1'b0; set_valid = 1'b0; clr_valid = 1'b0;
        ins_entry = '0; ins_exit = '0; set_entry = '0; clr_entry = '0;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        call_key = 16'h0700; ret_key = 16'h0800;
        #1;
        check("R1 call miss after reset", {31'd0, call_hit}, 32'd0);
        check("R1 return miss after reset", {31'd0, ret_hit}, 32'd0);
        check("R3 zero entry on miss", {16'd0, ret_entry}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            ins_valid = VECS[v].iv; ins_entry = VECS[v].ie; ins_exit = VECS[v].ix;
            set_valid = VECS[v].sv; set_entry = VECS[v].se;
            clr_valid = VECS[v].cv; clr_entry = VECS[v].ce;
            call_key  = VECS[v].ca; ret_key   = VECS[v].ra;
            #1;
            check($sformatf("R2 call hit vec %0d", v), {31'd0, call_hit}, {31'd0, VECS[v].ech});
            if (VECS[v].ech)
                check($sformatf("R2 call outstanding vec %0d", v),
                      {31'd0, call_outstanding}, {31'd0, VECS[v].eco});
            check($sformatf("R3 return hit vec %0d", v), {31'd0, ret_hit}, {31'd0, VECS[v].erh});
            check($sformatf("R3 return entry vec %0d", v), {16'd0, ret_entry}, {16'd0, VECS[v].ere});
        end

        // Directed: reset in mid-run drops every record.
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        call_key = 16'h1500; ret_key = 16'h1400;
        #1;
        check("R1 call miss after mid-run reset", {31'd0, call_hit}, 32'd0);
        check("R1 return miss after mid-run reset", {31'd0, ret_hit}, 32'd0);

        // Directed: first insert after reset lands and is found next cycle.
        @(negedge clk);
        ins_valid = 1'b1; ins_entry = 16'h2000; ins_exit = 16'h2100;
        @(negedge clk);
        idle();
        call_key = 16'h2000; ret_key = 16'h2100;
        #1;
        check("R4 insert visible after reset", {31'd0, call_hit}, 32'd1);
        check("R4 new flag clear", {31'd0, call_outstanding}, 32'd0);
        check("R3 paired entry", {16'd0, ret_entry}, 32'h2000);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule